// File: doc/BRIEF.md
# Infrared receiver run-length front end

This block sits behind a consumer infrared receiver. It turns the demodulated line into a stream of run-length entries. The raw line is first passed through a two-flop synchronizer. It is then sampled once per tick of a prescaled sample clock. The block counts how many consecutive samples the line spends at each level. Runs that are too short are treated as glitches and absorbed into the run around them. Each surviving run is written, as an 8-bit level-plus-length entry, to the write port of an external FIFO.

The receiver rests while no command is on the air. The first active (low) sample starts a receive. A receive ends when the line holds one level for a programmable idle gap. When that gap has passed, a sticky end-of-command flag is set and the block returns to rest. An interrupt output follows the flag while interrupts are enabled. The sample clock select, the glitch threshold and the idle threshold are plain inputs. They come from a register file that lives elsewhere.

Top module: `ir_pulse_front`

## Requirements
- R1: `clk_sel` sets one sample tick per 64, 128, 256 or 512 clock cycles for codes 0, 1, 2 and 3. Code 4 gives one tick every cycle. Codes 5, 6 and 7 behave as code 0.
- R2: At rest, an inactive (high) line produces no entries and never sets the flag. The first low sample starts a receive, and that sample is the first sample of the first run.
- R3: Each entry carries the run's line level in bit 7 and its length in samples in bits 6:0. The length is never zero.
- R4: A run of the opposite level that lasts `noise_thr` samples or fewer is dropped. Its samples are added to the surrounding run, which continues as a single entry.
- R5: With `noise_thr` = 0 every run is written, including single-sample runs.
- R6: A run longer than 127 samples is written as entries of length 127 with the same level, followed by the remainder.
- R7: While receiving, once the line has held one level for (`idle_thr`+1)×128 consecutive samples, the block sets `done_flag` and returns to rest. The unfinished run is not written, and no entry follows until the next low sample. A hold one sample shorter does not set the flag.
- R8: `done_flag` stays set until a `flag_clr` pulse. `irq` is high exactly while `done_flag` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_in | input | 1 | Raw infrared line, asynchronous, active low |
| clk_sel | input | 3 | Sample clock select |
| noise_thr | input | 6 | Longest run, in samples, that is treated as a glitch |
| idle_thr | input | 8 | Idle gap setting; the gap is (idle_thr+1)×128 samples |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears the end-of-command flag |
| wr_en | output | 1 | FIFO write strobe, one cycle per entry |
| wr_data | output | 8 | FIFO entry: level in bit 7, length in bits 6:0 |
| done_flag | output | 1 | Sticky end-of-command flag |
| irq | output | 1 | Interrupt request |

## Verification
Undivided sampling is exercised with three kinds of pattern. The first uses single-sample runs with filtering off. The second uses glitches exactly at the threshold and one sample longer, which separates an inclusive comparison from an exclusive one and shows whether a dropped glitch is added to the run. The third uses runs of several hundred samples, which shows whether long runs are split at 127 and whether a merge that crosses that limit is handled. The same kind of short pattern is repeated under divide-by-128 and under a reserved select code. Run lengths measured in samples then show whether the prescaler divides correctly. Idle gaps of exactly the threshold and one sample short show where the end of a command falls. A long high line at rest confirms that nothing is written before the first low sample.

// File: rtl/ir_pulse_front.sv
module ir_pulse_front #(
  parameter int LEN_W  = 7,
  parameter int NTHR_W = 6,
  parameter int ITHR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic [2:0]        clk_sel,
  input  logic [NTHR_W-1:0] noise_thr,
  input  logic [ITHR_W-1:0] idle_thr,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              wr_en,
  output logic [LEN_W:0]    wr_data,
  output logic              done_flag,
  output logic              irq
);
  localparam int CW    = LEN_W + 1;
  localparam int NW    = NTHR_W + 1;
  localparam int RW    = ITHR_W + 8;
  localparam logic [CW-1:0] MAXL = CW'(2**LEN_W - 1);

  logic [1:0]    sync;
  logic [8:0]    pcnt, plim;
  logic          tick, smp, recv, last, lvl;
  logic [RW-1:0] run, run_nx, lim;
  logic [CW-1:0] cnt, sum;
  logic [NW-1:0] nz;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], ir_in};

  assign smp = sync[1];

  always_comb
    case (clk_sel)
      3'd1:    plim = 9'd127;
      3'd2:    plim = 9'd255;
      3'd3:    plim = 9'd511;
      default: plim = 9'd63;
    endcase

  assign tick = (clk_sel == 3'd4) || (pcnt >= plim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 9'd1;

  assign run_nx = (smp == last) ? run + RW'(1) : RW'(1);
  assign lim    = (RW'(idle_thr) + RW'(1)) << 7;
  assign sum    = cnt + CW'(nz) + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      recv <= 1'b0; last <= 1'b1; lvl <= 1'b1; run <= '0;
      cnt <= '0; nz <= '0; wr_en <= 1'b0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (tick) begin
        last <= smp;
        if (!recv) begin
          if (!smp) begin
            recv <= 1'b1; lvl <= smp; cnt <= CW'(1); nz <= '0; run <= RW'(1);
          end
        end else begin
          run <= run_nx;
          if (run_nx >= lim) begin
            recv <= 1'b0;
          end else if (smp == lvl) begin
            nz <= '0;
            if (sum > MAXL) begin
              wr_en   <= 1'b1;
              wr_data <= {lvl, MAXL[LEN_W-1:0]};
              cnt     <= sum - MAXL;
            end else begin
              cnt <= sum;
            end
          end else if (nz >= NW'(noise_thr)) begin
            wr_en   <= 1'b1;
            wr_data <= {lvl, cnt[LEN_W-1:0]};
            lvl     <= smp;
            cnt     <= CW'(nz) + CW'(1);
            nz      <= '0;
          end else begin
            nz <= nz + NW'(1);
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             done_flag <= 1'b0;
    else if (tick && recv && run_nx >= lim) done_flag <= 1'b1;
    else if (flag_clr)                      done_flag <= 1'b0;

  assign irq = done_flag & irq_en;
endmodule

// File: rtl/ir_pulse_front_chk.sv
module ir_pulse_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] clk_sel,
  input logic       tick,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       done_flag,
  input logic       flag_clr,
  input logic       irq_en,
  input logic       irq
);
  logic [9:0] gap, exp_gap;
  logic [2:0] sel_q;
  logic       seen;

  always_comb
    case (clk_sel)
      3'd1:    exp_gap = 10'd128;
      3'd2:    exp_gap = 10'd256;
      3'd3:    exp_gap = 10'd512;
      3'd4:    exp_gap = 10'd1;
      default: exp_gap = 10'd64;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gap <= '0; sel_q <= '0; seen <= 1'b0;
    end else begin
      sel_q <= clk_sel;
      if (tick)               gap <= 10'd1;
      else if (gap != 10'h3ff) gap <= gap + 10'd1;
      if (clk_sel != sel_q) seen <= 1'b0;
      else if (tick)        seen <= 1'b1;
    end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen && clk_sel == sel_q) |-> gap == exp_gap);

  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data[6:0] != 7'd0);

  p_quiet_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> !wr_en);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind ir_pulse_front ir_pulse_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick),
  .wr_en(wr_en), .wr_data(wr_data), .done_flag(done_flag),
  .flag_clr(flag_clr), .irq_en(irq_en), .irq(irq)
);

// File: tb/tb_ir_pulse_front.sv
module tb_ir_pulse_front;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, ir_in = 1'b1;
  logic [2:0] clk_sel = 3'd4;
  logic [5:0] noise_thr = 6'd0;
  logic [7:0] idle_thr = 8'd0;
  logic       irq_en = 1'b1, flag_clr = 1'b0;
  logic       wr_en, done_flag, irq;
  logic [7:0] wr_data;

  ir_pulse_front dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .clk_sel(clk_sel),
    .noise_thr(noise_thr), .idle_thr(idle_thr), .irq_en(irq_en),
    .flag_clr(flag_clr), .wr_en(wr_en), .wr_data(wr_data),
    .done_flag(done_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, div = 1;
  string cur_req = "R3";
  logic [7:0] expq[$];
  bit m_recv = 0, m_last = 1, m_lvl = 1, m_done = 0;
  int m_run = 0, m_cnt = 0, m_nz = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) begin
        chk(0, {cur_req, " unexpected entry"}, int'(wr_data), -1);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(wr_data == e, {cur_req, " entry"}, int'(wr_data), int'(e));
      end
    end
  end

  task automatic step(input bit s);
    if (!m_recv) begin
      if (!s) begin m_recv = 1; m_lvl = 0; m_cnt = 1; m_nz = 0; m_run = 1; end
      m_last = s;
    end else begin
      m_run  = (s == m_last) ? m_run + 1 : 1;
      m_last = s;
      if (m_run >= (int'(idle_thr) + 1) * 128) begin
        m_recv = 0; m_done = 1;
      end else if (s == m_lvl) begin
        m_cnt = m_cnt + m_nz + 1; m_nz = 0;
        if (m_cnt > 127) begin expq.push_back({m_lvl, 7'd127}); m_cnt = m_cnt - 127; end
      end else begin
        m_nz++;
        if (m_nz > int'(noise_thr)) begin
          expq.push_back({m_lvl, 7'(m_cnt)});
          m_lvl = s; m_cnt = m_nz; m_nz = 0;
        end
      end
    end
  endtask

  task automatic put(input bit s, input int n);
    for (int i = 0; i < n; i++) begin
      ir_in = s;
      step(s);
      repeat (div) @(negedge clk);
    end
  endtask

  task automatic setup(input logic [2:0] sel, input logic [5:0] nt, input logic [7:0] it, input string req);
    @(negedge clk);
    clk_sel = sel; noise_thr = nt; idle_thr = it; cur_req = req;
    case (sel)
      3'd1: div = 128; 3'd2: div = 256; 3'd3: div = 512; 3'd4: div = 1;
      default: div = 64;
    endcase
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_cmd(input string req);
    put(1'b1, (int'(idle_thr) + 1) * 128);
    repeat (div * 3 + 8) @(negedge clk);
    chk(done_flag == m_done, {req, " done flag"}, int'(done_flag), int'(m_done));
    chk(expq.size() == 0, {req, " entries left"}, expq.size(), 0);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; m_done = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en && !done_flag && !irq, "R8 reset state", {wr_en, done_flag, irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: no filtering, single-sample runs
    setup(3'd4, 6'd0, 8'd0, "R5");
    put(0, 3); put(1, 1); put(0, 1); put(1, 1); put(0, 2); put(1, 2); put(0, 1);
    finish_cmd("R5");
    chk(irq == 1'b1, "R8 irq enabled", irq, 1);

    // R8: sticky flag, irq enable, clear
    irq_en = 1'b0;
    repeat (20) @(negedge clk);
    chk(done_flag == 1'b1, "R8 flag held", done_flag, 1);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq unmasked", irq, 1);
    clear_flag();
    chk(!done_flag && !irq, "R8 flag cleared", {done_flag, irq}, 0);

    // R2: long inactive line at rest
    setup(3'd4, 6'd0, 8'd0, "R2");
    put(1, 400);
    repeat (8) @(negedge clk);
    chk(!done_flag, "R2 no flag at rest", done_flag, 0);
    chk(expq.size() == 0, "R2 no entries at rest", expq.size(), 0);

    // R4: glitches at and above the threshold
    setup(3'd4, 6'd2, 8'd0, "R4");
    put(0, 10); put(1, 2); put(0, 10); put(1, 3); put(0, 5); put(1, 1);
    put(1, 6); put(0, 2); put(1, 4); put(0, 3); put(1, 2);
    finish_cmd("R4");
    clear_flag();

    // R6: runs longer than 127, including a merge across the limit
    setup(3'd4, 6'd1, 8'd3, "R6");
    put(0, 300); put(1, 5); put(0, 120); put(1, 1); put(0, 20); put(1, 254); put(0, 4);
    finish_cmd("R6");
    clear_flag();

    // R7: hold one sample short of the gap, then exactly the gap
    setup(3'd4, 6'd0, 8'd0, "R7");
    put(0, 2); put(1, 127); put(0, 127); put(1, 4);
    chk(!done_flag, "R7 no end one short", done_flag, 0);
    put(0, 3);
    finish_cmd("R7");
    put(1, 200);
    repeat (8) @(negedge clk);
    chk(expq.size() == 0, "R7 quiet after end", expq.size(), 0);
    clear_flag();

    // R1: divide by 128
    setup(3'd1, 6'd1, 8'd0, "R1");
    put(0, 4); put(1, 3); put(0, 1); put(0, 2); put(1, 5); put(0, 6);
    finish_cmd("R1");
    clear_flag();

    // R1: reserved code acts as divide by 64
    setup(3'd6, 6'd0, 8'd0, "R1");
    put(0, 5); put(1, 2); put(0, 3); put(1, 1); put(0, 2);
    finish_cmd("R1");
    clear_flag();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule